// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This unit guards a small word-addressed memory that several requesters share. Besides plain loads and stores it performs three indivisible read-modify-write operations: swap, test-and-set and fetch-and-increment. The read half and the write half of each of these happen back to back, and the unit takes no other request until the write is done. It also provides load-linked and store-conditional. A load-linked records a reservation for the requesting ID. A matching store-conditional writes only if that reservation survived, and it reports whether it wrote.

Requests arrive one at a time on a valid/ready port that carries an opcode, a requester ID, a word address and write data. Each accepted request produces exactly one response beat with read data and a success flag. Requests are served strictly in arrival order. Simple operations answer one cycle after acceptance. Read-modify-write operations answer two cycles after acceptance, and ready is low during the cycle between.

Top module: `amo_unit`

## Requirements
- R1: Reset (active-low `rst_n`) leaves ready high, response valid low, every memory word zero and every reservation cleared.
- R2: Opcode encoding is 0 load, 1 store, 2 swap, 3 test-and-set, 4 fetch-and-increment, 5 load-linked, 6 store-conditional, and 7 acts as load. A store writes the word and answers with data 0 and ok 1. A load answers with the stored word and ok 1. Both answer one cycle after acceptance.
- R3: Swap answers with the old word and leaves the supplied write data in memory, with ok 1.
- R4: Test-and-set answers with the old word. It writes the supplied data and answers ok 1 only when the old word is zero; otherwise memory is unchanged and ok is 0.
- R5: Fetch-and-increment answers with the old word and stores the old word plus one, wrapping modulo 2^DATA_W, with ok 1.
- R6: A read-modify-write request answers two cycles after acceptance. Ready is low in the cycle after acceptance and high again in the next.
- R7: Load-linked answers with the word and records a reservation for its ID at that address. A store-conditional whose ID holds a reservation at the same address writes the word and answers ok 1 and data 0.
- R8: A store-conditional with no matching reservation answers ok 0 and leaves memory unchanged. Every store-conditional, successful or not, consumes its own ID's reservation.
- R9: A store, any read-modify-write, or a successful store-conditional clears every requester's reservation on that address. Reservations on other addresses survive.
- R10: A new load-linked from an ID replaces that ID's earlier reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_op | input | 3 | Opcode (see R2) |
| req_id | input | ID_W | Requester ID |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data / swap or set value |
| rsp_valid | output | 1 | Response beat, one cycle wide |
| rsp_rdata | output | DATA_W | Old or loaded word |
| rsp_ok | output | 1 | Success flag |

## Verification
The hardest situations to reach from the ports are those where one requester's reservation is destroyed by a different requester. These include a store, an unsuccessful test-and-set, a fetch-and-increment, or another ID's successful store-conditional to the same word. Each must leave a reservation on a neighbouring word intact. The stimulus table interleaves several IDs so that reservations are set, attacked from another ID and then tried with a store-conditional, and a follow-up load shows whether the word changed. A directed reset in the middle of the run drops a live reservation and confirms that the memory was cleared.

// File: rtl/amo_pkg.sv
package amo_pkg;
   typedef enum logic [2:0] {
      OP_LOAD  = 3'd0,
      OP_STORE = 3'd1,
      OP_SWAP  = 3'd2,
      OP_TSET  = 3'd3,
      OP_FINC  = 3'd4,
      OP_LLINK = 3'd5,
      OP_SCOND = 3'd6,
      OP_ALTLD = 3'd7
   } amo_op_e;

   function automatic logic op_is_rmw(input logic [2:0] op);
      return (op == OP_SWAP) || (op == OP_TSET) || (op == OP_FINC);
   endfunction
endpackage

// File: rtl/amo_word_store.sv
module amo_word_store #(
   parameter int ADDR_W         = 4,
   parameter int DATA_W         = 16,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words_q [DEPTH];

   assign rd_data = words_q[rd_addr];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) words_q[i] <= '0;
            end else if (wr_en) begin
               words_q[wr_addr] <= wr_data;
            end
         end
      end else begin : g_noclear
         always_ff @(posedge clk) begin
            if (wr_en) words_q[wr_addr] <= wr_data;
         end
      end
   endgenerate
endmodule

// File: rtl/amo_resv_table.sv
module amo_resv_table #(
   parameter int NUM_REQ = 4,
   parameter int ADDR_W  = 4,
   parameter int ID_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [ID_W-1:0]   set_id,
   input  logic [ADDR_W-1:0] set_addr,
   input  logic              drop_en,
   input  logic [ID_W-1:0]   drop_id,
   input  logic              snoop_en,
   input  logic [ADDR_W-1:0] snoop_addr,
   input  logic [ID_W-1:0]   ask_id,
   input  logic [ADDR_W-1:0] ask_addr,
   output logic              ask_hit
);
   logic [NUM_REQ-1:0] live_q;
   logic [ADDR_W-1:0]  where_q [NUM_REQ];
   logic [NUM_REQ-1:0] match;

   genvar g;
   generate
      for (g = 0; g < NUM_REQ; g++) begin : g_slot
         logic mine_set, mine_drop, snooped;
         assign mine_set  = set_en  && (set_id  == ID_W'(g));
         assign mine_drop = drop_en && (drop_id == ID_W'(g));
         assign snooped   = snoop_en && live_q[g] && (where_q[g] == snoop_addr);
         assign match[g]  = live_q[g] && (where_q[g] == ask_addr);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               live_q[g]  <= 1'b0;
               where_q[g] <= '0;
            end else if (mine_set) begin
               live_q[g]  <= 1'b1;
               where_q[g] <= set_addr;
            end else if (mine_drop || snooped) begin
               live_q[g]  <= 1'b0;
            end
         end
      end
   endgenerate

   assign ask_hit = match[ask_id];
endmodule

// File: rtl/amo_rmw_alu.sv
module amo_rmw_alu
   import amo_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] arg,
   output logic [DATA_W-1:0] new_val,
   output logic              do_write
);
   always_comb begin
      new_val  = arg;
      do_write = 1'b1;
      case (op)
         OP_TSET: do_write = (old_val == '0);
         OP_FINC: new_val  = old_val + DATA_W'(1);
         default: ;
      endcase
   end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
   import amo_pkg::*;
#(
   parameter int ADDR_W         = 4,
   parameter int DATA_W         = 16,
   parameter int NUM_REQ        = 4,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int ID_W          = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_op,
   input  logic [ID_W-1:0]   req_id,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_ok
);
   generate
      if (NUM_REQ < 2)  begin : g_bad_req  $error("amo_unit: NUM_REQ must be at least 2"); end
      if (DATA_W < 2)   begin : g_bad_data $error("amo_unit: DATA_W must be at least 2"); end
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr $error("amo_unit: ADDR_W out of range"); end
   endgenerate

   logic              busy_q;
   logic [2:0]        op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] arg_q, old_q;
   logic              rsp_valid_q, rsp_ok_q;
   logic [DATA_W-1:0] rsp_rdata_q;

   logic              take, take_rmw, is_store, is_ll, is_sc, resv_hit;
   logic [DATA_W-1:0] cur_word, alu_new;
   logic              alu_we;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [DATA_W-1:0] mem_wdata;

   assign req_ready = !busy_q;
   assign take      = req_valid && req_ready;
   assign take_rmw  = take && op_is_rmw(req_op);
   assign is_store  = (req_op == OP_STORE);
   assign is_ll     = (req_op == OP_LLINK);
   assign is_sc     = (req_op == OP_SCOND);

   amo_rmw_alu #(.DATA_W(DATA_W)) u_alu (
      .op(op_q), .old_val(old_q), .arg(arg_q),
      .new_val(alu_new), .do_write(alu_we)
   );

   always_comb begin
      if (busy_q) begin
         mem_we    = alu_we;
         mem_waddr = addr_q;
         mem_wdata = alu_new;
      end else begin
         mem_we    = take && (is_store || (is_sc && resv_hit));
         mem_waddr = req_addr;
         mem_wdata = req_wdata;
      end
   end

   amo_word_store #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_addr(req_addr), .rd_data(cur_word),
      .wr_en(mem_we), .wr_addr(mem_waddr), .wr_data(mem_wdata)
   );

   amo_resv_table #(
      .NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .ID_W(ID_W)
   ) u_resv (
      .clk(clk), .rst_n(rst_n),
      .set_en(take && is_ll), .set_id(req_id), .set_addr(req_addr),
      .drop_en(take && is_sc), .drop_id(req_id),
      .snoop_en(busy_q || (take && (is_store || (is_sc && resv_hit)))),
      .snoop_addr(mem_waddr),
      .ask_id(req_id), .ask_addr(req_addr), .ask_hit(resv_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         op_q        <= '0;
         addr_q      <= '0;
         arg_q       <= '0;
         old_q       <= '0;
         rsp_valid_q <= 1'b0;
         rsp_ok_q    <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         if (busy_q) begin
            busy_q      <= 1'b0;
            rsp_valid_q <= 1'b1;
            rsp_rdata_q <= old_q;
            rsp_ok_q    <= alu_we;
         end else if (take_rmw) begin
            busy_q <= 1'b1;
            op_q   <= req_op;
            addr_q <= req_addr;
            arg_q  <= req_wdata;
            old_q  <= cur_word;
         end else if (take) begin
            rsp_valid_q <= 1'b1;
            rsp_rdata_q <= (is_store || is_sc) ? '0 : cur_word;
            rsp_ok_q    <= is_sc ? resv_hit : 1'b1;
         end
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_rdata = rsp_rdata_q;
   assign rsp_ok    = rsp_ok_q;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk
   import amo_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic [2:0] req_op,
   input logic       rsp_valid,
   input logic       rsp_ok
);
   logic accepted;
   assign accepted = req_valid && req_ready;

   // R6
   rmw_ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accepted && op_is_rmw(req_op) |=> !req_ready);

   // R6
   ready_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> req_ready);

   // R2
   simple_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accepted && !op_is_rmw(req_op) |=> rsp_valid);

   // R6
   rmw_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accepted && op_is_rmw(req_op) |=> !rsp_valid ##1 rsp_valid);

   // R6
   no_rsp_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> !rsp_valid);

   // R2
   store_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accepted && (req_op == OP_STORE) |=> rsp_ok);
endmodule

bind amo_unit amo_unit_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_op(req_op), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok)
);

// File: tb/amo_unit_bench.sv
`timescale 1ns/1ps
module amo_unit_bench;
   import amo_pkg::*;

   localparam int AW = 4;
   localparam int DW = 16;
   localparam int NR = 4;
   localparam int IW = 2;
   localparam int VW = 4 + 3 + IW + AW + DW + DW + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [2:0]    req_op = '0;
   logic [IW-1:0] req_id = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          rsp_ok;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   amo_unit #(.ADDR_W(AW), .DATA_W(DW), .NUM_REQ(NR)) u_amo_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_id(req_id), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok)
   );

   function automatic logic [VW-1:0] mk(input int rq, input amo_op_e op, input int id,
                                        input int a, input int wd, input int rd, input bit ok);
      return {4'(rq), op, IW'(id), AW'(a), DW'(wd), DW'(rd), ok};
   endfunction

   localparam int NV = 44;
   localparam logic [VW-1:0] VEC [NV] = '{
      // R2 store then load from another ID
      mk(2, OP_STORE, 0, 3, 'h1234, 0, 1), mk(2, OP_LOAD, 1, 3, 0, 'h1234, 1),
      // R3 swap
      mk(3, OP_SWAP, 0, 3, 'hBEEF, 'h1234, 1), mk(3, OP_LOAD, 2, 3, 0, 'hBEEF, 1),
      // R4 test-and-set on zero, then on nonzero
      mk(4, OP_TSET, 1, 5, 1, 0, 1), mk(4, OP_TSET, 2, 5, 7, 1, 0),
      mk(4, OP_LOAD, 0, 5, 0, 1, 1),
      // R5 fetch-and-increment twice, then wrap
      mk(5, OP_FINC, 3, 6, 0, 0, 1), mk(5, OP_FINC, 0, 6, 0, 1, 1),
      mk(5, OP_ALTLD, 1, 6, 0, 2, 1),
      mk(5, OP_STORE, 2, 14, 'hFFFF, 0, 1), mk(5, OP_FINC, 2, 14, 0, 'hFFFF, 1),
      mk(5, OP_LOAD, 2, 14, 0, 0, 1),
      // R7 linked pair succeeds
      mk(7, OP_LLINK, 0, 7, 0, 0, 1), mk(7, OP_SCOND, 0, 7, 'h55, 0, 1),
      mk(7, OP_LOAD, 1, 7, 0, 'h55, 1),
      // R8 reservation consumed, and no reservation at all
      mk(8, OP_SCOND, 0, 7, 'h66, 0, 0), mk(8, OP_LOAD, 0, 7, 0, 'h55, 1),
      mk(8, OP_SCOND, 3, 8, 9, 0, 0), mk(8, OP_LOAD, 3, 8, 0, 0, 1),
      mk(8, OP_LLINK, 1, 2, 0, 0, 1), mk(8, OP_SCOND, 1, 4, 'h77, 0, 0),
      mk(8, OP_LOAD, 1, 4, 0, 0, 1),
      // R9 store from another ID kills two reservations
      mk(9, OP_LLINK, 1, 9, 0, 0, 1), mk(9, OP_LLINK, 2, 9, 0, 0, 1),
      mk(9, OP_STORE, 3, 9, 'h11, 0, 1), mk(9, OP_SCOND, 1, 9, 'h22, 0, 0),
      mk(9, OP_SCOND, 2, 9, 'h33, 0, 0), mk(9, OP_LOAD, 0, 9, 0, 'h11, 1),
      // R9 other-address reservation survives
      mk(9, OP_LLINK, 1, 10, 0, 0, 1), mk(9, OP_LLINK, 2, 11, 0, 0, 1),
      mk(9, OP_STORE, 0, 10, 5, 0, 1), mk(9, OP_SCOND, 2, 11, 'h44, 0, 1),
      mk(9, OP_LOAD, 0, 11, 0, 'h44, 1),
      // R9 failing test-and-set still kills reservation
      mk(9, OP_LLINK, 0, 15, 0, 0, 1), mk(9, OP_STORE, 1, 15, 3, 0, 1),
      mk(9, OP_LLINK, 0, 15, 0, 3, 1), mk(9, OP_TSET, 2, 15, 8, 3, 0),
      mk(9, OP_SCOND, 0, 15, 'h7, 0, 0),
      // R9 successful conditional store kills other ID
      mk(9, OP_LLINK, 0, 1, 0, 0, 1), mk(9, OP_LLINK, 1, 1, 0, 0, 1),
      mk(9, OP_SCOND, 0, 1, 3, 0, 1), mk(9, OP_SCOND, 1, 1, 4, 0, 0),
      mk(9, OP_LOAD, 2, 1, 0, 3, 1)
   };

   task automatic chk(input bit good, input int rq, input string what,
                      input int act, input int exp);
      checks++;
      if (!good) begin
         fails++;
         $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
      end
   endtask

   task automatic do_op(input logic [2:0] op, input int id, input int a, input int wd,
                        output logic [DW-1:0] rd, output logic ok,
                        output int lat, output logic rdy_mid);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_id = IW'(id);
      req_addr = AW'(a); req_wdata = DW'(wd);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      rdy_mid = req_ready;
      lat = 1;
      while (!rsp_valid && lat < 10) begin
         @(negedge clk);
         lat++;
      end
      rd = rsp_rdata;
      ok = rsp_ok;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #200000;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [DW-1:0] rd;
      logic ok, rdy;
      int lat;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, 1, "ready in reset", req_ready, 1);
      chk(rsp_valid == 1'b0, 1, "rsp_valid in reset", rsp_valid, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         int rq, exp_lat;
         logic [2:0] op;
         v  = VEC[i];
         rq = int'(v[VW-1 -: 4]);
         op = v[VW-5 -: 3];
         do_op(op, int'(v[VW-8 -: IW]), int'(v[VW-8-IW -: AW]),
               int'(v[2*DW -: DW]), rd, ok, lat, rdy);
         chk(rd == v[DW:1], rq, $sformatf("vec %0d rdata", i), rd, v[DW:1]);
         chk(ok == v[0], rq, $sformatf("vec %0d ok", i), ok, v[0]);
         // R6 latency of read-modify-write versus simple operations
         exp_lat = op_is_rmw(op) ? 2 : 1;
         chk(lat == exp_lat, op_is_rmw(op) ? 6 : 2, $sformatf("vec %0d latency", i), lat, exp_lat);
         if (op_is_rmw(op))
            chk(rdy == 1'b0, 6, $sformatf("vec %0d ready mid", i), rdy, 0);
      end

      // R6 ready back high after the response
      chk(req_ready == 1'b1, 6, "ready after rmw", req_ready, 1);

      // R10 second link replaces first
      do_op(OP_LLINK, 3, 12, 0, rd, ok, lat, rdy);
      do_op(OP_LLINK, 3, 13, 0, rd, ok, lat, rdy);
      do_op(OP_SCOND, 3, 12, 'hAA, rd, ok, lat, rdy);
      chk(ok == 1'b0, 10, "old reservation replaced", ok, 0);
      do_op(OP_LOAD, 3, 12, 0, rd, ok, lat, rdy);
      chk(rd == '0, 10, "word untouched", rd, 0);
      do_op(OP_LLINK, 3, 12, 0, rd, ok, lat, rdy);
      do_op(OP_LLINK, 3, 13, 0, rd, ok, lat, rdy);
      do_op(OP_SCOND, 3, 13, 'hBB, rd, ok, lat, rdy);
      chk(ok == 1'b1, 10, "new reservation used", ok, 1);

      // R1 mid-run reset clears memory and reservations
      do_op(OP_LLINK, 2, 3, 0, rd, ok, lat, rdy);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk(req_ready == 1'b1 && rsp_valid == 1'b0, 1, "outputs under reset",
          {req_ready, rsp_valid}, 2);
      rst_n = 1'b1;
      do_op(OP_LOAD, 0, 3, 0, rd, ok, lat, rdy);
      chk(rd == '0, 1, "memory cleared", rd, 0);
      do_op(OP_SCOND, 2, 3, 'h5, rd, ok, lat, rdy);
      chk(ok == 1'b0, 1, "reservation cleared", ok, 0);

      finish_run();
   end
endmodule